// File: doc/BRIEF.md
# Staircase-Ramp Duty Cycle Comparator

This block turns a digitized feedback level into a pulse-width-modulated gate enable. A free-running 8-bit phase counter advances on every oscillator clock, and its upper four bits select one of sixteen reference steps. The reference falls by one unit per step, from 15 at step 0 down to 0 at step 15. On every clock the block compares the feedback code with the level of the current step. The gate enable is high while the feedback lies strictly below that level.

Over one full 256-clock period, the number of clocks with the gate high therefore grows as the feedback falls. A feedback code at or above the top level holds the gate low for the whole period. A negative feedback code holds it high for the whole period. A one-clock strobe marks the start of each period.

The feedback code is a level, not a stream. It is sampled on every clock edge without a handshake, and it has no back-pressure: the most recent value always wins. The step index and the strobe are plain status outputs.

Top module: `staircase_duty_cmp`

## Requirements
- R1: With `rst` high at a rising edge (synchronous, active high), the next sample shows `gate_en`=0, `step_idx`=0 and `period_stb`=0.
- R2: `step_idx` is bits [7:4] of an internal 8-bit count. The count is 0 in reset, becomes 1 at the first edge with `rst` low, and then increments by one on every edge, so the index advances once every 16 clocks.
- R3: `period_stb` is high for exactly one clock. That clock is the one that follows the edge where the count wraps from 255 to 0, so the strobe repeats every 256 clocks and always coincides with `step_idx`=0.
- R4: Step k has reference level 15-k. After an edge with `rst` low, `gate_en` is 1 exactly when the signed `fb_code` sampled at that edge is less than 15 minus the `step_idx` shown after that edge.
- R5: When the sampled `fb_code` equals the level of the step, `gate_en` is 0.
- R6: `fb_code` of 15 (at the top level) gives `gate_en`=0 on every clock, which is 0% duty.
- R7: Any negative `fb_code` (sign bit 4 set) gives `gate_en`=1 on every clock outside reset, which is 100% duty.
- R8: For a constant `fb_code` f in 0..15, any 256 consecutive clocks outside reset contain exactly 16*(15-f) clocks with `gate_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_code | input | 5 | Signed two's-complement feedback level; 15 is the top step, 0 the bottom step |
| gate_en | output | 1 | Registered gate enable |
| step_idx | output | 4 | Index of the current reference step |
| period_stb | output | 1 | One-clock strobe at the start of each period |

## Verification
The wrap of the phase counter is where two functions meet in one cycle. At that edge the strobe rises, and the gate enable also swings from the bottom-step decision to the top-step decision. The bench provokes this by holding mid-range feedback codes across several wraps. In that cycle it judges, independently, that the strobe is set, that the index reads 0, and that the gate matches the comparison against level 15. A late or early look-ahead would show up there as a gate that still follows step 15.

// File: rtl/stair_pkg.sv
package stair_pkg;
  // Default geometry shared by the phase counter and the comparator.
  localparam int unsigned STAIR_CNT_W  = 8;
  localparam int unsigned STAIR_STEP_W = 4;

  // Encoded decision of one clock, kept together so the top can forward it.
  typedef enum logic {
    GATE_OFF = 1'b0,
    GATE_ON  = 1'b1
  } gate_state_e;
endpackage

// File: rtl/stair_phase_cnt.sv
module stair_phase_cnt #(
  parameter int unsigned CNT_W  = stair_pkg::STAIR_CNT_W,
  parameter int unsigned STEP_W = stair_pkg::STAIR_STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STEP_W-1:0] step_cur,
  output logic [STEP_W-1:0] step_nxt,
  output logic              wrap_stb
);
  localparam int unsigned TOP = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      wrap_stb <= 1'b0;
    end else begin
      cnt_q    <= cnt_inc;
      wrap_stb <= (cnt_q == {CNT_W{1'b1}});
    end
  end

  // The index now shown, and the index that the next edge will show.
  assign step_cur = cnt_q[TOP -: STEP_W];
  assign step_nxt = rst ? '0 : cnt_inc[TOP -: STEP_W];
endmodule

// File: rtl/stair_level_map.sv
module stair_level_map #(
  parameter int unsigned STEP_W = stair_pkg::STAIR_STEP_W
) (
  input  logic [STEP_W-1:0] step,
  output logic [STEP_W-1:0] level
);
  // (2^W - 1) - k equals the bitwise inverse of k, so no subtractor is needed.
  for (genvar i = 0; i < STEP_W; i++) begin : g_bit
    assign level[i] = ~step[i];
  end
endmodule

// File: rtl/stair_gate_cmp.sv
module stair_gate_cmp #(
  parameter int unsigned STEP_W = stair_pkg::STAIR_STEP_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [STEP_W:0]   fb_code,
  input  logic        [STEP_W-1:0] level_nxt,
  output logic                     gate_q
);
  import stair_pkg::*;

  logic signed [STEP_W:0] level_s;
  gate_state_e            decide;

  assign level_s = $signed({1'b0, level_nxt});
  assign decide  = (fb_code < level_s) ? GATE_ON : GATE_OFF;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= decide;
  end
endmodule

// File: rtl/staircase_duty_cmp.sv
module staircase_duty_cmp #(
  parameter int unsigned CNT_W  = stair_pkg::STAIR_CNT_W,
  parameter int unsigned STEP_W = stair_pkg::STAIR_STEP_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [STEP_W:0] fb_code,
  output logic                   gate_en,
  output logic [STEP_W-1:0]      step_idx,
  output logic                   period_stb
);
  logic [STEP_W-1:0] step_nxt;
  logic [STEP_W-1:0] level_nxt;

  stair_phase_cnt #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step_cur (step_idx),
    .step_nxt (step_nxt),
    .wrap_stb (period_stb)
  );

  stair_level_map #(.STEP_W(STEP_W)) u_map (
    .step  (step_nxt),
    .level (level_nxt)
  );

  stair_gate_cmp #(.STEP_W(STEP_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .fb_code   (fb_code),
    .level_nxt (level_nxt),
    .gate_q    (gate_en)
  );
endmodule

// File: rtl/stair_duty_chk.sv
module stair_duty_chk #(
  parameter int unsigned STEP_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic signed [STEP_W:0] fb_code,
  input logic                   gate_en,
  input logic [STEP_W-1:0]      step_idx,
  input logic                   period_stb
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!gate_en && step_idx == '0 && !period_stb)); // R1

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (step_idx == $past(step_idx) || step_idx == $past(step_idx) + 1'b1)); // R2

  AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> step_idx == '0); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    period_stb |=> !period_stb); // R3

  AST_EQUAL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fb_code) == $signed({1'b0, ~step_idx})) |-> !gate_en); // R5

  AST_TOP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(fb_code[STEP_W]) && $past(fb_code[STEP_W-1:0]) == {STEP_W{1'b1}}) |-> !gate_en); // R6

  AST_NEG_FULL_ON: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fb_code[STEP_W])) |-> gate_en); // R7
endmodule

bind staircase_duty_cmp stair_duty_chk #(.STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fb_code    (fb_code),
  .gate_en    (gate_en),
  .step_idx   (step_idx),
  .period_stb (period_stb)
);

// File: tb/staircase_duty_cmp_tb.sv
module staircase_duty_cmp_tb;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [4:0] fb  = 5'sd0;
  logic              gate_en;
  logic [3:0]        step_idx;
  logic              period_stb;

  int n_chk  = 0;
  int n_fail = 0;
  int m      = 0;
  bit done   = 1'b0;
  int high_cnt;

  always #5 clk = ~clk;

  staircase_duty_cmp u_dut (
    .clk        (clk),
    .rst        (rst),
    .fb_code    (fb),
    .gate_en    (gate_en),
    .step_idx   (step_idx),
    .period_stb (period_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: update the bench's own count, then check at the falling edge.
  task automatic tick();
    bit r_at_edge;
    bit stb_e;
    bit gate_e;
    int lvl;
    int f;
    @(posedge clk);
    r_at_edge = rst;
    f = int'(fb);
    stb_e = 1'b0;
    if (r_at_edge) m = 0;
    else begin
      stb_e = (m == 255);
      m = (m + 1) % 256;
    end
    @(negedge clk);
    lvl = 15 - (m / 16);
    gate_e = !r_at_edge && (f < lvl);
    if (r_at_edge) begin
      chk(gate_en == 1'b0, "R1 gate", gate_en, 0);
      chk(step_idx == 4'd0, "R1 step", step_idx, 0);
      chk(period_stb == 1'b0, "R1 strobe", period_stb, 0);
    end else begin
      chk(step_idx == 4'(m / 16), "R2 step", step_idx, m / 16);
      chk(period_stb == stb_e, "R3 strobe", period_stb, stb_e);
      if (f >= 15)      chk(gate_en == gate_e, "R6 gate", gate_en, gate_e);
      else if (f < 0)   chk(gate_en == gate_e, "R7 gate", gate_en, gate_e);
      else if (f == lvl) chk(gate_en == gate_e, "R5 gate", gate_en, gate_e);
      else              chk(gate_en == gate_e, "R4 gate", gate_en, gate_e);
    end
  endtask

  task automatic t_reset(input int cycles);
    rst = 1'b1;
    repeat (cycles) tick();
    rst = 1'b0;
  endtask

  // Constant feedback over 256 clocks; the high count must match R8.
  task automatic t_duty(input int f, input int exp_high);
    fb = 5'(f);
    tick();
    high_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      tick();
      if (gate_en) high_cnt++;
    end
    chk(high_cnt == exp_high, "R8 duty", high_cnt, exp_high);
  endtask

  // Strobe spacing across a wrap with mid-range feedback (R3 with R4).
  task automatic t_wrap_gap();
    int gap;
    int seen;
    fb = 5'sd6;
    seen = 0;
    gap = 0;
    for (int i = 0; i < 600; i++) begin
      tick();
      if (seen > 0) gap++;
      if (period_stb) begin
        if (seen > 0) chk(gap == 256, "R3 spacing", gap, 256);
        chk(gate_en == 1'b1, "R4 gate at wrap", gate_en, 1);
        seen++;
        gap = 0;
      end
    end
    chk(seen >= 2, "R3 count", seen, 2);
  endtask

  initial begin
    t_reset(3);
    t_duty(15, 0);
    t_duty(-1, 256);
    t_duty(-16, 256);
    t_duty(0, 240);
    t_duty(7, 128);
    t_duty(3, 192);
    t_duty(14, 16);
    t_wrap_gap();
    repeat (37) tick();
    t_reset(2);
    t_duty(10, 80);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule